// File: doc/BRIEF.md
# TDM Transmit Link Framer

This block drives one serial TDM transmit link. It works out the bit boundaries of the link, keeps a bit counter inside the frame and shifts parallel words out as a serial stream, most significant bit first. The link clock can be made inside the block by dividing the system clock, or it can be taken from the link and edge-detected. The frame sync can be produced by the block or taken from the far end and used to realign the bit counter.

Two sync shapes are supported. The generic shape marks the first bit of each frame with a level that software selects. The boundary shape is an active-low pulse that covers the last bit of one frame and the first bit of the next. In the generic shape the link-clock edge that marks a bit boundary can be rising or falling. An unframed mode treats the link as a plain bit pipe: frames are fixed at 1024 bits, an incoming sync is ignored, and an outgoing sync still pulses once per 1024 bits so that downstream logic can use it or drop it. The word source sits behind `word_i`/`word_req` and is not part of the block.

Top module: `tdm_tx_framer`

## Requirements
- R1: While `cfg_valid` is low, and after reset, the block shows the idle state from the next cycle on: `ser_o`=1, `sync_o` at its inactive level, and `frame_start`, `word_req` and `bit_strobe` all 0.
- R2: With `cfg_clk_dir_out`=1 the block drives `lnk_clk_o` with a period of 2*DIV_HALF system cycles and starts one bit per period. The bit boundary is the rising edge of `lnk_clk_o` when `cfg_clk_fall`=0 and the falling edge when it is 1. `bit_strobe` is high for the one cycle that follows the cycle in which the boundary edge appears.
- R3: With `cfg_clk_dir_out`=0 each boundary edge of `lnk_clk_i` (rising when `cfg_clk_fall`=0, falling when it is 1) starts exactly one bit, after a three-stage synchronizer.
- R4: In the boundary sync shape (`cfg_alt_fmt`=1) `cfg_clk_fall` has no effect, and the boundary is always the rising edge.
- R5: `ser_o` changes only in `bit_strobe` cycles. It carries each captured word most significant bit first. A word is captured from `word_i` when its first bit starts, and that is at every WORD_W-th bit and at bit 0 of every frame.
- R6: `word_req` is high together with `bit_strobe` at the start of the bit that comes just before a capture. That bit is the last bit of a word or the last bit of a frame.
- R7: In framed mode a frame has `cfg_frame_len_m1`+1 bits. `frame_start` is high with `bit_strobe` on bit 0, and the first bit after `cfg_valid` rises is bit 0.
- R8: With the sync as an output in the generic shape, `sync_o` sits at the active level (high when `cfg_sync_high`=1, low when it is 0) during bit 0 only.
- R9: With the sync as an output in the boundary shape, `sync_o` is low during the last bit of each frame and during bit 0, and high otherwise.
- R10: With the sync as an input in the generic shape (framed), `lnk_sync_i` is sampled at every bit boundary. If it is at the active level there, the bit that starts at that boundary becomes bit 0.
- R11: With the sync as an input in the boundary shape (framed), a low level sampled at two boundaries in a row makes the bit that starts at the second boundary bit 0.
- R12: With `cfg_unframed`=1 a frame is 1024 bits whatever `cfg_frame_len_m1` holds, `lnk_sync_i` has no effect, and an output sync still pulses once every 1024 bits.
- R13: `lnk_clk_oe` and `lnk_sync_oe` follow `cfg_clk_dir_out` and `cfg_sync_dir_out` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration valid, enables the link |
| cfg_clk_dir_out | input | 1 | 1: block drives the link clock |
| cfg_sync_dir_out | input | 1 | 1: block drives the frame sync |
| cfg_alt_fmt | input | 1 | 1: boundary-straddling active-low sync shape |
| cfg_sync_high | input | 1 | Generic shape active level (1 high, 0 low) |
| cfg_clk_fall | input | 1 | Generic shape: bit boundary on falling edge |
| cfg_unframed | input | 1 | Free-running unframed mode |
| cfg_frame_len_m1 | input | LEN_W | Frame length in bits minus one |
| lnk_clk_i | input | 1 | Link clock from the pin |
| lnk_clk_o | output | 1 | Link clock to the pin |
| lnk_clk_oe | output | 1 | Link clock output enable |
| lnk_sync_i | input | 1 | Frame sync from the pin |
| lnk_sync_o | output | 1 | Frame sync to the pin |
| lnk_sync_oe | output | 1 | Frame sync output enable |
| word_i | input | WORD_W | Next parallel word from the source |
| word_req | output | 1 | Strobe: present the next word |
| frame_start | output | 1 | Strobe: bit 0 of a frame begins |
| bit_strobe | output | 1 | Strobe: a new bit begins |
| ser_o | output | 1 | Serial data |

## Verification
The hardest case to reach from the ports is a realignment in the middle of a frame, where the incoming sync has to be seen at one chosen bit boundary and at no other. The stimulus is keyed to the observed `bit_strobe`: the sync is raised in the strobe cycle of a chosen bit and dropped at a later strobe. The synchronized level is therefore settled at the boundaries that should see it and gone by the next one. The same injection is repeated with the unframed mode on, and there the bench expects frame starts only at multiples of 1024 bits.

// File: rtl/tdmf_pkg.sv
package tdmf_pkg;

  // frame length used by the free-running unframed mode
  localparam int UNF_BITS = 1024;

  // shape and active level of the frame sync
  typedef enum logic [1:0] {
    SYN_GEN_HI = 2'd0,
    SYN_GEN_LO = 2'd1,
    SYN_ALT    = 2'd2
  } tdmf_sfmt_e;

endpackage

// File: rtl/tdmf_bitclk.sv
module tdmf_bitclk #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic clk_dir_out,
  input  logic eff_fall,
  input  logic lnk_clk_i,
  input  logic lnk_sync_i,
  output logic tick,
  output logic sync_s,
  output logic clk_o
);

  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic c1, c2, c3;
  logic y1;
  logic ph;
  logic div_wrap;

  // input synchronizers; the sync path is one stage shorter than the clock path so
  // that, in a tick cycle, sync_s holds the level seen at the boundary edge
  always_ff @(posedge clk) begin
    if (rst) begin
      c1 <= 1'b0; c2 <= 1'b0; c3 <= 1'b0;
      y1 <= 1'b0; sync_s <= 1'b0;
    end else begin
      c1 <= lnk_clk_i; c2 <= c1; c3 <= c2;
      y1 <= lnk_sync_i; sync_s <= y1;
    end
  end

  generate
    if (DIV_HALF > 1) begin : g_div
      logic [DW-1:0] div;
      always_ff @(posedge clk) begin
        if (rst || !valid || !clk_dir_out) div <= '0;
        else if (div == DW'(DIV_HALF - 1)) div <= '0;
        else div <= div + 1'b1;
      end
      assign div_wrap = (div == DW'(DIV_HALF - 1));
    end else begin : g_nodiv
      assign div_wrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= 1'b0; tick <= 1'b0; clk_o <= 1'b0;
    end else if (!valid) begin
      ph <= 1'b0; tick <= 1'b0; clk_o <= eff_fall;
    end else if (clk_dir_out) begin
      tick <= 1'b0;
      if (div_wrap) begin
        ph    <= ~ph;
        clk_o <= ~ph ^ eff_fall;
        tick  <= ~ph;
      end
    end else begin
      tick <= eff_fall ? (c3 & ~c2) : (c2 & ~c3);
    end
  end

endmodule

// File: rtl/tdmf_frame.sv
module tdmf_frame
  import tdmf_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  tdmf_sfmt_e       sfmt,
  input  logic             sync_dir_out,
  input  logic             unframed,
  input  logic [LEN_W-1:0] last,
  input  logic             tick,
  input  logic             sync_s,
  output logic             nxt_first,
  output logic             nxt_last,
  output logic             strobe,
  output logic             frame_start,
  output logic             sync_o
);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] nxt_cnt;
  logic             act_lvl;
  logic             alt;
  logic             lvl_act;
  logic             prev_act;
  logic             evt;
  logic             gen_act;

  assign alt     = (sfmt == SYN_ALT);
  assign act_lvl = (sfmt == SYN_GEN_HI);
  assign lvl_act = (sync_s == act_lvl);

  // realignment from an incoming sync, only in framed mode
  assign evt = !sync_dir_out && !unframed && lvl_act && (!alt || prev_act);

  always_comb begin
    if (evt || cnt >= last) nxt_cnt = '0;
    else                    nxt_cnt = cnt + 1'b1;
  end

  assign nxt_first = (nxt_cnt == '0);
  assign nxt_last  = (nxt_cnt == last);
  assign gen_act   = alt ? (nxt_first || nxt_last) : nxt_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; prev_act <= 1'b0;
      strobe <= 1'b0; frame_start <= 1'b0; sync_o <= 1'b0;
    end else if (!valid) begin
      cnt         <= last;
      prev_act    <= 1'b0;
      strobe      <= 1'b0;
      frame_start <= 1'b0;
      sync_o      <= ~act_lvl;
    end else begin
      strobe      <= tick;
      frame_start <= tick && nxt_first;
      if (tick) begin
        cnt      <= nxt_cnt;
        prev_act <= lvl_act;
        sync_o   <= (sync_dir_out && gen_act) ? act_lvl : ~act_lvl;
      end
    end
  end

endmodule

// File: rtl/tdmf_shift.sv
module tdmf_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              tick,
  input  logic              nxt_first,
  input  logic              nxt_last,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              word_req
);

  localparam int PW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(WORD_W - 1);

  logic [PW-1:0]     pos;
  logic [PW-1:0]     nxt_pos;
  logic [WORD_W-1:0] sh;
  logic              load;

  assign load    = nxt_first || (pos == POS_LAST);
  assign nxt_pos = load ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !valid) begin
      pos      <= POS_LAST;
      sh       <= '1;
      ser_o    <= 1'b1;
      word_req <= 1'b0;
    end else begin
      word_req <= tick && ((nxt_pos == POS_LAST) || nxt_last);
      if (tick) begin
        pos <= nxt_pos;
        if (load) begin
          ser_o <= word_i[WORD_W-1];
          sh    <= {word_i[WORD_W-2:0], 1'b0};
        end else begin
          ser_o <= sh[WORD_W-1];
          sh    <= {sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdmf_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LEN_W    = 10,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic              cfg_clk_dir_out,
  input  logic              cfg_sync_dir_out,
  input  logic              cfg_alt_fmt,
  input  logic              cfg_sync_high,
  input  logic              cfg_clk_fall,
  input  logic              cfg_unframed,
  input  logic [LEN_W-1:0]  cfg_frame_len_m1,
  input  logic              lnk_clk_i,
  output logic              lnk_clk_o,
  output logic              lnk_clk_oe,
  input  logic              lnk_sync_i,
  output logic              lnk_sync_o,
  output logic              lnk_sync_oe,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_req,
  output logic              frame_start,
  output logic              bit_strobe,
  output logic              ser_o
);

  localparam logic [LEN_W-1:0] UNF_LAST = LEN_W'(UNF_BITS - 1);

  tdmf_sfmt_e       sfmt;
  logic             eff_fall;
  logic [LEN_W-1:0] last;
  logic             tick;
  logic             sync_s;
  logic             nxt_first;
  logic             nxt_last;

  assign sfmt     = cfg_alt_fmt ? SYN_ALT : (cfg_sync_high ? SYN_GEN_HI : SYN_GEN_LO);
  assign eff_fall = cfg_clk_fall && !cfg_alt_fmt;
  assign last     = cfg_unframed ? UNF_LAST : cfg_frame_len_m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lnk_clk_oe  <= 1'b0;
      lnk_sync_oe <= 1'b0;
    end else begin
      lnk_clk_oe  <= cfg_clk_dir_out;
      lnk_sync_oe <= cfg_sync_dir_out;
    end
  end

  tdmf_bitclk #(.DIV_HALF(DIV_HALF)) i_bitclk (
    .clk(clk), .rst(rst), .valid(cfg_valid),
    .clk_dir_out(cfg_clk_dir_out), .eff_fall(eff_fall),
    .lnk_clk_i(lnk_clk_i), .lnk_sync_i(lnk_sync_i),
    .tick(tick), .sync_s(sync_s), .clk_o(lnk_clk_o)
  );

  tdmf_frame #(.LEN_W(LEN_W)) i_frame (
    .clk(clk), .rst(rst), .valid(cfg_valid), .sfmt(sfmt),
    .sync_dir_out(cfg_sync_dir_out), .unframed(cfg_unframed),
    .last(last), .tick(tick), .sync_s(sync_s),
    .nxt_first(nxt_first), .nxt_last(nxt_last),
    .strobe(bit_strobe), .frame_start(frame_start), .sync_o(lnk_sync_o)
  );

  tdmf_shift #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .valid(cfg_valid), .tick(tick),
    .nxt_first(nxt_first), .nxt_last(nxt_last), .word_i(word_i),
    .ser_o(ser_o), .word_req(word_req)
  );

endmodule

// File: rtl/tdm_tx_framer_chk.sv
module tdm_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic cfg_valid,
  input logic cfg_clk_dir_out,
  input logic cfg_sync_dir_out,
  input logic cfg_alt_fmt,
  input logic cfg_sync_high,
  input logic bit_strobe,
  input logic frame_start,
  input logic word_req,
  input logic ser_o,
  input logic lnk_sync_o,
  input logic lnk_clk_oe,
  input logic lnk_sync_oe
);

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> (ser_o && !frame_start && !word_req && !bit_strobe));

  // R5
  ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && $past(cfg_valid) && !bit_strobe) |-> $stable(ser_o));

  // R6
  req_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    word_req |-> bit_strobe);

  // R7
  start_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> bit_strobe);

  // R8
  gen_sync_level_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && frame_start && cfg_sync_dir_out && !cfg_alt_fmt)
      |-> (lnk_sync_o == cfg_sync_high));

  // R9
  alt_sync_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && frame_start && cfg_sync_dir_out && cfg_alt_fmt) |-> !lnk_sync_o);

  // R13
  clk_oe_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lnk_clk_oe == $past(cfg_clk_dir_out)));

  // R13
  sync_oe_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lnk_sync_oe == $past(cfg_sync_dir_out)));

endmodule

bind tdm_tx_framer tdm_tx_framer_chk i_chk (.*);

// File: tb/test_tdm_tx_framer.sv
module test_tdm_tx_framer;

  localparam int WW = 8;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_valid = 1'b0;
  logic          cfg_clk_dir_out = 1'b0;
  logic          cfg_sync_dir_out = 1'b0;
  logic          cfg_alt_fmt = 1'b0;
  logic          cfg_sync_high = 1'b1;
  logic          cfg_clk_fall = 1'b0;
  logic          cfg_unframed = 1'b0;
  logic [LW-1:0] cfg_frame_len_m1 = '0;
  logic          lnk_clk_i = 1'b0;
  logic          lnk_sync_i = 1'b0;
  logic [WW-1:0] word_i = '0;
  logic          lnk_clk_o, lnk_clk_oe, lnk_sync_o, lnk_sync_oe;
  logic          word_req, frame_start, bit_strobe, ser_o;

  int  tests = 0;
  int  fails = 0;
  int  wcnt  = 0;
  bit  ext_run = 1'b0;

  always #2 clk = ~clk;

  tdm_tx_framer i_tdm_tx_framer (.*);

  // external link clock: half period of 6 system cycles
  initial begin
    int h = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        h++;
        if (h == 6) begin h = 0; lnk_clk_i = ~lnk_clk_i; end
      end else h = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [WW-1:0] word_of(input int n);
    return WW'((n * 91 + 163) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit co, input bit so, input bit alt, input bit hi,
                       input bit fall, input bit unf, input int flen);
    cfg_valid = 1'b0;
    repeat (4) @(negedge clk);
    cfg_clk_dir_out = co; cfg_sync_dir_out = so; cfg_alt_fmt = alt;
    cfg_sync_high = hi; cfg_clk_fall = fall; cfg_unframed = unf;
    cfg_frame_len_m1 = LW'(flen - 1);
    lnk_sync_i = alt ? 1'b1 : !hi;
    wcnt = 0;
    word_i = word_of(0);
    ext_run = !co;
    lnk_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(lnk_clk_oe == co, "R13 clk oe", lnk_clk_oe, co);
    chk(lnk_sync_oe == so, "R13 sync oe", lnk_sync_oe, so);
    cfg_valid = 1'b1;
  endtask

  // follows nbits bits, checks every output against the bench model;
  // inj >= 0 injects an incoming sync at that bit
  task automatic run_bits(input int nbits, input int flen, input int inj, input bit honored);
    int b = 0;
    logic [WW-1:0] cur = '0;
    logic p1 = 1'b0, p2 = 1'b0;
    bit eff = cfg_clk_fall && !cfg_alt_fmt;
    bit act = cfg_alt_fmt ? 1'b0 : cfg_sync_high;
    int rb = cfg_alt_fmt ? inj + 2 : inj + 1;
    for (int n = 0; n < nbits; n++) begin
      int g = 0;
      do begin
        p2 = p1; p1 = lnk_clk_o;
        @(negedge clk); g++;
      end while (!bit_strobe && g < 400);
      chk(bit_strobe, "R2/R3 strobe", bit_strobe, 1);
      if (inj >= 0 && honored && n == rb) b = 0;
      if (b % WW == 0) cur = word_i;
      if (inj >= 0 && n == rb)
        chk(frame_start == honored, cfg_unframed ? "R12 ignore" :
            (cfg_alt_fmt ? "R11" : "R10"), frame_start, honored);
      else
        chk(frame_start == (b == 0), cfg_unframed ? "R12 frame" : "R7",
            frame_start, b == 0);
      chk(ser_o == cur[WW-1-(b%WW)], "R5", ser_o, cur[WW-1-(b%WW)]);
      chk(word_req == ((b % WW == WW-1) || b == flen-1), "R6", word_req,
          (b % WW == WW-1) || b == flen-1);
      if (cfg_sync_dir_out) begin
        bit on = cfg_alt_fmt ? (b == 0 || b == flen-1) : (b == 0);
        bit e  = on ? act : !act;
        chk(lnk_sync_o == e, cfg_alt_fmt ? "R9" : (cfg_unframed ? "R12 sync" : "R8"),
            lnk_sync_o, e);
      end
      if (cfg_clk_dir_out && n > 0) begin
        chk(lnk_clk_o == !eff && p2 == eff, cfg_alt_fmt ? "R4" : "R2",
            {p2, lnk_clk_o}, {eff, !eff});
      end
      if (!cfg_clk_dir_out)
        chk(lnk_clk_i == !eff, "R3", lnk_clk_i, !eff);
      if (word_req) begin wcnt++; word_i = word_of(wcnt); end
      if (inj >= 0 && n == inj) lnk_sync_i = act;
      if (inj >= 0 && n == (cfg_alt_fmt ? inj + 2 : inj + 1)) lnk_sync_i = !act;
      b = (b + 1) % flen;
    end
  endtask

  task automatic t_reset;
    chk(ser_o == 1'b1, "R1 ser", ser_o, 1);
    chk(!frame_start && !word_req && !bit_strobe, "R1 strobes",
        {frame_start, word_req, bit_strobe}, 0);
    chk(lnk_sync_o == 1'b0, "R1 sync", lnk_sync_o, 0);
    chk(!lnk_clk_oe && !lnk_sync_oe, "R13 reset", {lnk_clk_oe, lnk_sync_oe}, 0);
  endtask

  task automatic t_int_gen_high;
    setup(1, 1, 0, 1, 0, 0, 16);
    run_bits(40, 16, -1, 0);
  endtask

  task automatic t_int_gen_low_fall;
    setup(1, 1, 0, 0, 1, 0, 12);
    run_bits(40, 12, -1, 0);
  endtask

  task automatic t_alt_out;
    setup(1, 1, 1, 1, 1, 0, 10);
    run_bits(30, 10, -1, 0);
  endtask

  task automatic t_ext_clock;
    setup(0, 1, 0, 1, 1, 0, 16);
    run_bits(30, 16, -1, 0);
    setup(0, 1, 0, 1, 0, 0, 16);
    run_bits(20, 16, -1, 0);
  endtask

  task automatic t_sync_in_gen;
    setup(1, 0, 0, 1, 0, 0, 16);
    run_bits(40, 16, 5, 1);
    setup(1, 0, 0, 0, 0, 0, 16);
    run_bits(40, 16, 21, 1);
  endtask

  task automatic t_sync_in_alt;
    setup(1, 0, 1, 1, 0, 0, 16);
    run_bits(40, 16, 20, 1);
  endtask

  task automatic t_unframed;
    setup(1, 1, 0, 1, 0, 1, 16);
    run_bits(1030, 1024, -1, 0);
    setup(1, 0, 0, 1, 0, 1, 16);
    run_bits(1030, 1024, 300, 0);
  endtask

  task automatic t_idle_again;
    cfg_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(ser_o == 1'b1, "R1 ser after drop", ser_o, 1);
    chk(!frame_start && !word_req && !bit_strobe, "R1 strobes after drop",
        {frame_start, word_req, bit_strobe}, 0);
    chk(lnk_sync_o == !cfg_sync_high, "R1 sync after drop", lnk_sync_o, !cfg_sync_high);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_int_gen_high();
    t_int_gen_low_fall();
    t_alt_out();
    t_ext_clock();
    t_sync_in_gen();
    t_sync_in_alt();
    t_unframed();
    t_idle_again();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule